// File: doc/BRIEF.md
# Multiplexed Switch Panel Scanner

This block reads a small front panel through an external 16-channel analog multiplexer. The panel has one 5-position rotary switch, one 3-position rotary switch and three push buttons, wired to 11 of the multiplexer's inputs. A closed contact pulls the shared return line to ground. An open contact leaves the line pulled high. On each periodic scan tick, the block drives the 4-bit select bus through the used channels in turn. It waits a settling time on each channel and then records whether the line is low.

At the end of a sweep, the block packs the results into one status byte and raises a one-cycle valid strobe. The byte holds the index of the closed contact in each rotary group and one bit for each button, with a pressed button read as 1. A host samples the byte on the strobe. The scan tick is expected about every 10 ms. The settling time defaults to 200 clock cycles, which is 1 µs at 200 MHz.

Top module: `panel_scanner`

## Requirements
- R1: While reset is high, and after it is released, the select bus is 0, the status byte is 0x00 and the valid strobe is low.
- R2: A sweep starts on a scan tick seen while idle. The select bus then takes the values 0, 1, ... 10 in ascending order, one value per channel, and returns to 0. Values 11 to 15 are never driven.
- R3: Each channel is held for SETTLE_CYC cycles, and the return line is sampled at the last of them. The select bus moves to the next channel SETTLE_CYC cycles after the current channel was first driven. The valid strobe is high in the cycle that follows 11*SETTLE_CYC+2 rising edges, counting from the first edge that sees the tick.
- R4: Bits [7:5] of the status byte hold the index 0..4 of the low channel among channels 0..4 (the 5-position switch). Bits [4:3] hold the index 0..2 of the low channel among channels 5..7 (the 3-position switch).
- R5: Bits [2:0] are the buttons. Bit k reports channel 8+k, and it reads 1 when that channel's line was low (pressed) and 0 when the line was high.
- R6: If no channel of a rotary group reads low in a sweep, that group's field keeps its previous value.
- R7: If several channels of one rotary group read low, the lowest-numbered channel sets the field.
- R8: The status byte changes only together with a valid pulse. The pulse lasts exactly one cycle and occurs once per sweep.
- R9: A scan tick that arrives during a sweep is ignored. It neither restarts the sweep nor adds a second valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scanTick | input | 1 | One-cycle request to start a sweep |
| retLineN | input | 1 | Multiplexer return line, low when the selected contact is closed |
| selBus | output | 4 | Multiplexer channel select |
| statusByte | output | 8 | Packed panel state: 5-position index, 3-position index, buttons |
| byteValid | output | 1 | One-cycle strobe marking a newly published status byte |

## Verification
The bench drives the scan tick on a falling edge and counts rising edges from that point. It samples every output on the falling edge that follows an edge. The select bus must read 0 after edge SETTLE_CYC and 1 after edge SETTLE_CYC+1. The valid pulse and the new byte must appear after edge 11*SETTLE_CYC+2, and the bench checks that exact count. A driver task pushes the byte predicted from the contact pattern and the previously held fields. A monitor pops one expected byte per valid pulse, so an extra or missing pulse from an ignored mid-sweep tick shows up as a mismatch.

// File: rtl/panel_scanner_pkg.sv
package panel_scanner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_PUBLISH = 2'd2
  } scanState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic sample;   // capture the return line for the current channel
    logic publish;  // pack captured results into the status byte
  } scanCtl_t;

endpackage

// File: rtl/panel_scanner_ctrl.sv
module panel_scanner_ctrl
  import panel_scanner_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int NUM_CH     = 11,
  parameter int SETTLE_CYC = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scanTick,
  output logic [SEL_W-1:0] selBus,
  output scanCtl_t         ctl
);

  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [SEL_W-1:0] CH_LAST  = SEL_W'(NUM_CH - 1);

  scanState_t       state;
  logic [CNT_W-1:0] settleCnt;
  logic [SEL_W-1:0] chIdx;
  logic             settleDone;

  assign settleDone = (state == ST_SETTLE) && (settleCnt == CNT_LAST);
  assign selBus     = chIdx;

  always_comb begin
    ctl         = '0;
    ctl.sample  = settleDone;
    ctl.publish = (state == ST_PUBLISH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      chIdx     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (scanTick) begin
            state     <= ST_SETTLE;
            settleCnt <= '0;
            chIdx     <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleDone) begin
            settleCnt <= '0;
            if (chIdx == CH_LAST) begin
              state <= ST_PUBLISH;
              chIdx <= '0;
            end else begin
              chIdx <= chIdx + 1'b1;
            end
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_PUBLISH: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_scanner_dpath.sv
module panel_scanner_dpath
  import panel_scanner_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int ROT_A = 5,
  parameter int ROT_B = 3,
  parameter int BTN_N = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  scanCtl_t                      ctl,
  input  logic [SEL_W-1:0]              selBus,
  input  logic                          retLineN,
  output logic [ROTA_W+ROTB_W+BTN_N-1:0] statusByte,
  output logic                          byteValid
);

  localparam int ROTA_W = $clog2(ROT_A);
  localparam int ROTB_W = $clog2(ROT_B);
  localparam int NUM_CH = ROT_A + ROT_B + BTN_N;
  localparam int B_BASE = ROT_A;
  localparam int K_BASE = ROT_A + ROT_B;
  localparam int OUT_W  = ROTA_W + ROTB_W + BTN_N;

  logic [NUM_CH-1:0] lowSeen;
  logic [ROTA_W-1:0] idxA, heldA;
  logic [ROTB_W-1:0] idxB, heldB;
  logic              hitA, hitB;
  logic [BTN_N-1:0]  btnBits;

  // capture: one flag per channel, set when the line was low
  always_ff @(posedge clk) begin
    if (rst) begin
      lowSeen <= '0;
    end else if (ctl.sample) begin
      lowSeen[selBus] <= ~retLineN;
    end
  end

  assign heldA = statusByte[OUT_W-1 -: ROTA_W];
  assign heldB = statusByte[BTN_N +: ROTB_W];

  // priority decode: scan downward so the lowest closed contact wins
  always_comb begin
    idxA = '0;
    hitA = 1'b0;
    for (int i = ROT_A - 1; i >= 0; i--) begin
      if (lowSeen[i]) begin
        idxA = ROTA_W'(i);
        hitA = 1'b1;
      end
    end
  end

  always_comb begin
    idxB = '0;
    hitB = 1'b0;
    for (int i = ROT_B - 1; i >= 0; i--) begin
      if (lowSeen[B_BASE + i]) begin
        idxB = ROTB_W'(i);
        hitB = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < BTN_N; k++) begin : g_btn
    assign btnBits[k] = lowSeen[K_BASE + k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusByte <= '0;
      byteValid  <= 1'b0;
    end else begin
      byteValid <= ctl.publish;
      if (ctl.publish) begin
        statusByte <= {(hitA ? idxA : heldA), (hitB ? idxB : heldB), btnBits};
      end
    end
  end

endmodule

// File: rtl/panel_scanner.sv
module panel_scanner
  import panel_scanner_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int ROT_A      = 5,
  parameter int ROT_B      = 3,
  parameter int BTN_N      = 3,
  parameter int SETTLE_CYC = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scanTick,
  input  logic             retLineN,
  output logic [SEL_W-1:0] selBus,
  output logic [7:0]       statusByte,
  output logic             byteValid
);

  localparam int NUM_CH = ROT_A + ROT_B + BTN_N;

  scanCtl_t ctl;

  panel_scanner_ctrl #(
    .SEL_W(SEL_W), .NUM_CH(NUM_CH), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .scanTick(scanTick), .selBus(selBus), .ctl(ctl)
  );

  panel_scanner_dpath #(
    .SEL_W(SEL_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .BTN_N(BTN_N)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .selBus(selBus), .retLineN(retLineN),
    .statusByte(statusByte), .byteValid(byteValid)
  );

endmodule

// File: rtl/panel_scanner_chk.sv
module panel_scanner_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] selBus,
  input logic [7:0]       statusByte,
  input logic             byteValid
);

  // R2: unused channels 11..15 are never selected
  a_r2_sel_range: assert property (@(posedge clk) disable iff (rst)
    selBus <= SEL_W'(10));

  // R2: the select only steps up by one or returns to channel 0
  a_r2_sel_step: assert property (@(posedge clk) disable iff (rst)
    (selBus != $past(selBus)) |-> (selBus == $past(selBus) + 1'b1 || selBus == '0));

  // R4: rotary fields stay within their group sizes
  a_r4_field_range: assert property (@(posedge clk) disable iff (rst)
    statusByte[7:5] <= 3'd4 && statusByte[4:3] <= 2'd2);

  // R8: the strobe lasts a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    byteValid |=> !byteValid);

  // R8: the byte holds still between strobes
  a_r8_byte_stable: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> $stable(statusByte));

endmodule

bind panel_scanner panel_scanner_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .selBus(selBus),
  .statusByte(statusByte), .byteValid(byteValid)
);

// File: tb/panel_scanner_test.sv
`timescale 1ns/1ps
module panel_scanner_test;

  localparam int S = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scanTick = 1'b0;
  logic [3:0] selBus;
  logic [7:0] statusByte;
  logic       byteValid;
  logic [10:0] closed = '0;
  logic       retLineN;

  int checks = 0;
  int failures = 0;
  int pushes = 0;
  int pulses = 0;
  logic [7:0] expQ[$];
  logic [2:0] modelA = '0;
  logic [1:0] modelB = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // multiplexer model: closed contact grounds the line
  assign retLineN = (selBus < 4'd11) ? ~closed[selBus] : 1'b1;

  panel_scanner uut (
    .clk(clk), .rst(rst), .scanTick(scanTick), .retLineN(retLineN),
    .selBus(selBus), .statusByte(statusByte), .byteValid(byteValid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected byte from the requirements (R4 R5 R6 R7)
  function automatic logic [7:0] predict(input logic [10:0] c);
    logic [2:0] a = modelA;
    logic [1:0] b = modelB;
    for (int i = 4; i >= 0; i--) if (c[i]) a = 3'(i);
    for (int i = 2; i >= 0; i--) if (c[5+i]) b = 2'(i);
    modelA = a;
    modelB = b;
    return {a, b, c[10], c[9], c[8]};
  endfunction

  // monitor: one expected byte per strobe
  always @(negedge clk) begin
    if (!rst && byteValid) begin
      pulses++;
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 actual=unexpected strobe expected=none");
      end else begin
        check("R4/R5 byte", {8'h0, statusByte}, {8'h0, expQ.pop_front()});
      end
    end
  end

  task automatic sweep(input logic [10:0] c, input bit extraTick);
    int n = 0;
    @(negedge clk);
    closed = c;
    expQ.push_back(predict(c));
    pushes++;
    scanTick = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      scanTick = 1'b0;
      if (extraTick && n == 5 * S) scanTick = 1'b1;   // R9 mid-sweep tick
      if (n == S)     check("R3 sel held", {12'h0, selBus}, 16'd0);
      if (n == S + 1) check("R2 sel step", {12'h0, selBus}, 16'd1);
      if (byteValid) break;
      if (n > 12 * S + 10) break;
    end
    check("R3 latency", 16'(n), 16'(11 * S + 2));
    @(negedge clk);
    check("R2 sel idle", {12'h0, selBus}, 16'd0);
    check("R8 pulse low", {15'h0, byteValid}, 16'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 sel", {12'h0, selBus}, 16'd0);
    check("R1 byte", {8'h0, statusByte}, 16'd0);
    check("R1 valid", {15'h0, byteValid}, 16'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 byte after release", {8'h0, statusByte}, 16'd0);
    check("R1 valid after release", {15'h0, byteValid}, 16'd0);

    sweep(11'b101_010_00100, 0);   // R4 R5: pos 2, pos 1, buttons 8 and 10
    sweep(11'b000_001_10000, 0);   // R4: pos 4, pos 0, no buttons
    sweep(11'b000_000_00000, 0);   // R6: both groups hold
    sweep(11'b111_110_01010, 0);   // R7: lowest wins in both groups, all buttons
    sweep(11'b010_100_00001, 1);   // R9: extra tick mid-sweep ignored
    sweep(11'b000_000_00001, 0);   // R6: only group B holds

    repeat (3 * S) @(negedge clk);
    check("R9 pulse count", 16'(pulses), 16'(pushes));
    check("R8 queue drained", 16'(expQ.size()), 16'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule